// File: doc/BRIEF.md
# Two-Bit Digit Multiply-Accumulate Unit

This block multiplies two unsigned 8-bit operands and folds the product into a wide running total. The multiplier operand is read two bits at a time. Each two-bit digit steers a four-way selector that picks zero, the multiplicand, twice the multiplicand or three times the multiplicand. The triple is formed once by a single adder and shared by every selector. This gives four 10-bit rows where a plain shift-and-add array would have eight. The rows are weighted by successive powers of four and added into a 16-bit product. That product then feeds a 24-bit registered accumulator.

The host drives the operands every cycle and uses two controls. One adds the current product into the total. The other restarts the total. When both are raised together, the total restarts from the current product instead of from zero, so a new dot product can begin without a dead cycle. A sticky flag records that the total has wrapped past its top bit at least once since the last restart.

Top module: `recoded_mac`

## Requirements
- R1: While the active-low reset is low, and on the first cycle after it is released, the total reads 0 and the wrap flag reads 0.
- R2: Each digit b[2k+1:2k] (k = 0..3) selects a row: code 00 gives 0, 01 gives a, 10 gives a shifted left by one, 11 gives 3a. Row k is weighted by 4^k, so the product equals the unsigned value a*b.
- R3: With the add control high and the restart control low, at the next rising edge the total becomes (total + a*b) modulo 2^24.
- R4: With both controls low, the total and the wrap flag keep their values whatever a and b carry.
- R5: With only the restart control high, at the next rising edge the total becomes 0 and the wrap flag becomes 0.
- R6: With both controls high, at the next rising edge the total becomes a*b and the wrap flag becomes 0.
- R7: An add whose sum carries out of bit 23 sets the wrap flag at that same edge. The flag then stays set through later adds and holds until a restart clears it. It is never set by any other event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opA | input | 8 | Multiplicand, unsigned |
| opB | input | 8 | Multiplier, unsigned, read as four two-bit digits |
| accEn | input | 1 | Add the current product into the total |
| accClr | input | 1 | Restart the total (loads the product if accEn is also high) |
| accOut | output | 24 | Registered running total |
| ovfFlag | output | 1 | Sticky wrap flag |

## Verification
Restart and add can be requested in the same cycle, and that cycle must load the product and drop the wrap flag. The bench raises both controls together directly after runs of adds, again right after the flag has been set, and at random within long streams. It compares the total and the flag with a model in which restart takes priority and seeds the total. The cycle in which the sum crosses 2^24 is hit exactly by repeated 255*255 adds. The flag is then expected at that edge, expected to survive holds and adds, and expected to fall only when a restart arrives.

// File: rtl/recmac_pkg.sv
package recmac_pkg;

  // Two-bit multiplier digit codes, one per row selector
  typedef enum logic [1:0] {
    DIG_ZERO  = 2'b00,
    DIG_ONE   = 2'b01,
    DIG_TWO   = 2'b10,
    DIG_THREE = 2'b11
  } digit_t;

  // Strobes from control to datapath; at most one is high per cycle
  typedef struct packed {
    logic doLoad;   // total <= product, flag cleared
    logic doZero;   // total <= 0, flag cleared
    logic doAdd;    // total <= total + product, flag accumulates carry
  } mac_strobe_t;

endpackage

// File: rtl/recmac_ctrl.sv
module recmac_ctrl
  import recmac_pkg::*;
(
  input  logic        accEn,
  input  logic        accClr,
  output mac_strobe_t strobe
);

  // Restart wins over add; a combined request seeds the total
  always_comb begin
    strobe        = '0;
    strobe.doLoad = accClr && accEn;
    strobe.doZero = accClr && !accEn;
    strobe.doAdd  = !accClr && accEn;
  end

endmodule

// File: rtl/recmac_ppgen.sv
module recmac_ppgen
  import recmac_pkg::*;
#(
  parameter int A_W = 8,
  parameter int B_W = 8,
  localparam int DIGITS = B_W / 2,
  localparam int PP_W   = A_W + 2
) (
  input  logic [A_W-1:0]               opA,
  input  logic [B_W-1:0]               opB,
  output logic [DIGITS-1:0][PP_W-1:0]  ppRows
);

  logic [PP_W-1:0] aOne;
  logic [PP_W-1:0] aTwo;
  logic [PP_W-1:0] aThree;

  assign aOne   = PP_W'(opA);
  assign aTwo   = PP_W'({opA, 1'b0});
  // The only carry chain in the row generator, shared by all selectors
  assign aThree = aOne + aTwo;

  for (genvar k = 0; k < DIGITS; k++) begin : g_row
    digit_t          dig;
    logic [PP_W-1:0] rowVal;

    assign dig = digit_t'(opB[2*k +: 2]);

    always_comb begin
      unique case (dig)
        DIG_ZERO:  rowVal = '0;
        DIG_ONE:   rowVal = aOne;
        DIG_TWO:   rowVal = aTwo;
        DIG_THREE: rowVal = aThree;
        default:   rowVal = '0;
      endcase
    end

    assign ppRows[k] = rowVal;
  end

endmodule

// File: rtl/recmac_rowsum.sv
module recmac_rowsum #(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter bit SUM_TREE = 1'b1,
  localparam int DIGITS = B_W / 2,
  localparam int PP_W   = A_W + 2,
  localparam int PROD_W = A_W + B_W,
  localparam int PAIRS  = (DIGITS + 1) / 2,
  localparam int PAIR_W = PP_W + 3
) (
  input  logic [DIGITS-1:0][PP_W-1:0] ppRows,
  output logic [PROD_W-1:0]           product
);

  if (SUM_TREE) begin : g_tree
    // First level: fold each row pair (weights 1 and 4) into one value
    logic [PAIRS-1:0][PAIR_W-1:0] pairSum;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      if (2*p + 1 < DIGITS) begin : g_full
        assign pairSum[p] = PAIR_W'(ppRows[2*p]) + PAIR_W'({ppRows[2*p+1], 2'b00});
      end else begin : g_single
        assign pairSum[p] = PAIR_W'(ppRows[2*p]);
      end
    end

    // Second level: pairs carry weights of 16^p
    always_comb begin
      product = '0;
      for (int p = 0; p < PAIRS; p++) begin
        product = product + (PROD_W'(pairSum[p]) << (4*p));
      end
    end
  end else begin : g_chain
    // Straight chain of row additions, shortest to describe, deepest in logic
    always_comb begin
      product = '0;
      for (int k = 0; k < DIGITS; k++) begin
        product = product + (PROD_W'(ppRows[k]) << (2*k));
      end
    end
  end

endmodule

// File: rtl/recmac_acc.sv
module recmac_acc
  import recmac_pkg::*;
#(
  parameter int PROD_W = 16,
  parameter int ACC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mac_strobe_t       strobe,
  input  logic [PROD_W-1:0] product,
  output logic [ACC_W-1:0]  accOut,
  output logic              ovfFlag
);

  logic [ACC_W-1:0] prodExt;
  logic [ACC_W:0]   sumExt;

  assign prodExt = ACC_W'(product);
  assign sumExt  = {1'b0, accOut} + {1'b0, prodExt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accOut  <= '0;
      ovfFlag <= 1'b0;
    end else if (strobe.doLoad) begin
      accOut  <= prodExt;
      ovfFlag <= 1'b0;
    end else if (strobe.doZero) begin
      accOut  <= '0;
      ovfFlag <= 1'b0;
    end else if (strobe.doAdd) begin
      accOut  <= sumExt[ACC_W-1:0];
      ovfFlag <= ovfFlag | sumExt[ACC_W];
    end
  end

endmodule

// File: rtl/recmac_datapath.sv
module recmac_datapath
  import recmac_pkg::*;
#(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter int ACC_W    = 24,
  parameter bit SUM_TREE = 1'b1,
  localparam int DIGITS = B_W / 2,
  localparam int PP_W   = A_W + 2,
  localparam int PROD_W = A_W + B_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  input  mac_strobe_t      strobe,
  output logic [ACC_W-1:0] accOut,
  output logic             ovfFlag
);

  logic [DIGITS-1:0][PP_W-1:0] ppRows;
  logic [PROD_W-1:0]           product;

  recmac_ppgen #(.A_W(A_W), .B_W(B_W)) ppgen_i (
    .opA    (opA),
    .opB    (opB),
    .ppRows (ppRows)
  );

  recmac_rowsum #(.A_W(A_W), .B_W(B_W), .SUM_TREE(SUM_TREE)) rowsum_i (
    .ppRows  (ppRows),
    .product (product)
  );

  recmac_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W)) acc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .product (product),
    .accOut  (accOut),
    .ovfFlag (ovfFlag)
  );

endmodule

// File: rtl/recoded_mac.sv
module recoded_mac
  import recmac_pkg::*;
#(
  parameter int A_W      = 8,
  parameter int B_W      = 8,
  parameter int ACC_W    = 24,
  parameter bit SUM_TREE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [A_W-1:0]   opA,
  input  logic [B_W-1:0]   opB,
  input  logic             accEn,
  input  logic             accClr,
  output logic [ACC_W-1:0] accOut,
  output logic             ovfFlag
);

  mac_strobe_t strobe;

  recmac_ctrl ctrl_i (
    .accEn  (accEn),
    .accClr (accClr),
    .strobe (strobe)
  );

  recmac_datapath #(
    .A_W(A_W), .B_W(B_W), .ACC_W(ACC_W), .SUM_TREE(SUM_TREE)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .accOut  (accOut),
    .ovfFlag (ovfFlag)
  );

endmodule

// File: rtl/recmac_checker.sv
module recmac_checker #(
  parameter int A_W   = 8,
  parameter int B_W   = 8,
  parameter int ACC_W = 24,
  localparam int PROD_W = A_W + B_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [A_W-1:0]   opA,
  input logic [B_W-1:0]   opB,
  input logic             accEn,
  input logic             accClr,
  input logic [ACC_W-1:0] accOut,
  input logic             ovfFlag
);

  logic [PROD_W-1:0] chkProd;
  logic [ACC_W:0]    chkSum;
  logic              addReq;

  assign chkProd = PROD_W'(opA) * PROD_W'(opB);
  assign chkSum  = {1'b0, accOut} + (ACC_W+1)'(chkProd);
  assign addReq  = accEn && !accClr;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (accOut == '0 && !ovfFlag));

  a_r3_add_step: assert property (@(posedge clk) disable iff (!rst_n)
    addReq |=> accOut == $past(chkSum[ACC_W-1:0]));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!accEn && !accClr) |=> ($stable(accOut) && $stable(ovfFlag)));

  a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accClr && !accEn) |=> (accOut == '0 && !ovfFlag));

  a_r6_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    (accClr && accEn) |=> (accOut == ACC_W'($past(chkProd)) && !ovfFlag));

  a_r7_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (addReq && chkSum[ACC_W]) |=> ovfFlag);

  a_r7_wrap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !accClr) |=> ovfFlag);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovfFlag && !(addReq && chkSum[ACC_W])) |=> !ovfFlag);

endmodule

bind recoded_mac recmac_checker #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .opA     (opA),
  .opB     (opB),
  .accEn   (accEn),
  .accClr  (accClr),
  .accOut  (accOut),
  .ovfFlag (ovfFlag)
);

// File: tb/recoded_mac_tb_top.sv
module recoded_mac_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  opA;
  logic [7:0]  opB;
  logic        accEn;
  logic        accClr;
  logic [23:0] accOut;
  logic        ovfFlag;

  int          checks = 0;
  int          errors = 0;
  logic [23:0] expAcc = '0;
  logic        expOvf = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  recoded_mac dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .opA     (opA),
    .opB     (opB),
    .accEn   (accEn),
    .accClr  (accClr),
    .accOut  (accOut),
    .ovfFlag (ovfFlag)
  );

  // Reference product built from the digit rule: row k = digit*a, weight 4^k
  function automatic logic [15:0] refProd(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] s = '0;
    for (int k = 0; k < 4; k++) begin
      s = s + ((16'(y[2*k +: 2]) * 16'(x)) << (2*k));
    end
    return s;
  endfunction

  task automatic checkState(input string req);
    checks++;
    if (accOut !== expAcc || ovfFlag !== expOvf) begin
      errors++;
      $display("FAIL %s: acc=%0d ovf=%0b expected acc=%0d ovf=%0b",
               req, accOut, ovfFlag, expAcc, expOvf);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, update model, check
  task automatic runCycle(input logic [7:0] x, input logic [7:0] y,
                          input logic en, input logic clr, input string req);
    logic [24:0] s;
    opA = x; opB = y; accEn = en; accClr = clr;
    @(posedge clk);
    #1;
    if (clr && en) begin
      expAcc = 24'(refProd(x, y)); expOvf = 1'b0;
    end else if (clr) begin
      expAcc = '0; expOvf = 1'b0;
    end else if (en) begin
      s = {1'b0, expAcc} + 25'(refProd(x, y));
      expAcc = s[23:0];
      expOvf = expOvf | s[24];
    end
    @(negedge clk);
    checkState(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D2E3F4));
    rst_n = 1'b0; opA = '0; opB = '0; accEn = 1'b0; accClr = 1'b0;
    repeat (3) @(negedge clk);
    checkState("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    checkState("R1 after release");

    // R2: each digit code in every position, loaded with restart+add
    runCycle(8'd255, 8'd255, 1, 1, "R2 255x255");
    runCycle(8'd173, 8'h00,  1, 1, "R2 digits 00");
    runCycle(8'd173, 8'h55,  1, 1, "R2 digits 01");
    runCycle(8'd173, 8'hAA,  1, 1, "R2 digits 10");
    runCycle(8'd173, 8'hFF,  1, 1, "R2 digits 11");
    runCycle(8'd201, 8'h1B,  1, 1, "R2 mixed digits");
    runCycle(8'd0,   8'hE4,  1, 1, "R2 zero multiplicand");

    // R3 accumulate, R4 hold with busy operands, R5 restart
    runCycle(8'd17, 8'd3, 0, 1, "R5 restart");
    for (int i = 0; i < 8; i++) runCycle(8'($urandom), 8'($urandom), 1, 0, "R3 add");
    for (int i = 0; i < 4; i++) runCycle(8'($urandom), 8'($urandom), 0, 0, "R4 hold");
    runCycle(8'hFF, 8'hFF, 0, 1, "R5 restart after adds");
    runCycle(8'hFF, 8'hFF, 0, 0, "R4 hold at zero");

    // R7: 258 adds of 65025 stay below 2^24, the 259th wraps
    for (int i = 0; i < 258; i++) runCycle(8'hFF, 8'hFF, 1, 0, "R7 approach");
    runCycle(8'hFF, 8'hFF, 1, 0, "R7 wrap edge");
    if (!expOvf) begin
      errors++;
      $display("FAIL R7: model wrap not reached, actual=0 expected=1");
    end
    runCycle(8'h12, 8'h34, 0, 0, "R7 sticky over hold");
    runCycle(8'h00, 8'h00, 1, 0, "R7 sticky over add");
    runCycle(8'h40, 8'h40, 1, 1, "R6 load clears flag");
    runCycle(8'h40, 8'h40, 1, 0, "R3 add after load");

    // Random mix, including same-cycle restart and add
    for (int i = 0; i < 3000; i++) begin
      logic en, clr;
      en  = ($urandom % 100) < 75;
      clr = ($urandom % 100) < 6;
      runCycle(8'($urandom), 8'($urandom), en, clr,
               (clr && en) ? "R6 random" : clr ? "R5 random" : en ? "R3 random" : "R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule